// File: doc/BRIEF.md
# Decimating Six-Channel Input Sequencer

This block takes a stream of 10-bit words on one shared bus and spreads them over six channel registers, one word per active edge of a panel clock. The panel clock comes in as a plain data input and is sampled by a faster system clock. Rising and falling panel-clock edges are found from those samples. The data bus and the control strobes pass through the same sampling pipeline, so they stay aligned with the panel clock.

A start strobe arms a load sequence. The sequence then begins on the next active edge. A direction input picks whether loading begins at the lowest channel and climbs, or at the highest channel and descends. Each channel has two registers: a load register filled by the sequencer, and an output register. A transfer strobe seen on a rising panel-clock edge copies all six load registers into the output registers on the following falling edge, so every output changes in the same cycle. A mode input selects whether the rising or the falling panel-clock edge is the active edge for loading.

Top module: `hexa_load_sequencer`

## Requirements
- R1: While `rst` is high on a clock edge, all load and output registers clear to zero, `seq_done` goes to 0, `next_ch` goes to 0 and no sequence is in progress.
- R2: With `edge_sel` = 1, words load only on rising panel-clock edges. With `edge_sel` = 0, words load only on falling panel-clock edges. Edges of the other polarity load nothing.
- R3: A sequence begins on an active edge only if `start_in` was 1 on the previous active edge. The word present on the beginning edge goes into the first channel.
- R4: With `dir_sel` = 0 at the beginning edge, the first channel is 0 and each later active edge loads the next higher channel. With `dir_sel` = 1, the first channel is 5 and the order descends. Exactly one word is loaded per active edge, and channel i is `ch_out[10*i+9 : 10*i]`.
- R5: After the sixth word of a sequence, the sequencer is idle. `seq_done` reads 1 and `next_ch` reads 0. Further words are ignored until a new start qualifies, and `seq_done` clears when that start qualifies.
- R6: A start that qualifies in the middle of a sequence restarts loading at the first channel for the direction sampled on that edge.
- R7: If `xfer_in` is 1 on a rising panel-clock edge, then on the next falling edge all six output registers take the load-register values as they stood just before that falling edge. A word loaded on that same falling edge is not included.
- R8: The output registers do not change except through a transfer. A rising edge with `xfer_in` = 0 leads to no copy.
- R9: While a sequence is in progress, `next_ch` shows the channel that the next active edge will load.
- R10: All effects of a panel-clock transition are visible at the outputs after the third system-clock rising edge that follows the transition, with all inputs changing together with `pclk_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pclk_in | input | 1 | Panel clock, sampled as data |
| edge_sel | input | 1 | 1: rising edge active, 0: falling edge active |
| dir_sel | input | 1 | 0: ascending from channel 0, 1: descending from channel 5 |
| start_in | input | 1 | Start-sequence strobe |
| xfer_in | input | 1 | Transfer strobe, sampled on rising panel-clock edges |
| data_in | input | 10 | Input word, bit 9 is the MSB |
| ch_out | output | 60 | Six output registers, channel i at bits 10*i+9 down to 10*i |
| seq_done | output | 1 | Set after the last load of a sequence |
| next_ch | output | 3 | Channel to be loaded next |

## Verification
Every result of a panel-clock transition, whether a load, an index step, the done flag or a transfer copy, appears exactly three system-clock cycles after the inputs change. The bench drives all inputs together on a falling system-clock edge. It then waits three falling edges, pushes the expected register image into the scoreboard, and waits a few more cycles before the next transition. This means a design that is one cycle early or late fails the comparison. Each half period of the panel clock produces one compared image, and the image covers all six output words, `seq_done` and `next_ch`.

// File: rtl/hls_pkg.sv
package hls_pkg;
    localparam int unsigned CH_N  = 6;
    localparam int unsigned WORD_W = 10;
    localparam int unsigned IDX_W = $clog2(CH_N);
    localparam int unsigned CNT_W = $clog2(CH_N + 1);
endpackage

// File: rtl/hls_edge_sync.sv
module hls_edge_sync #(
    parameter int unsigned W = hls_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pclk_in,
    input  logic [W-1:0] data_in,
    input  logic         start_in,
    input  logic         xfer_in,
    input  logic         esel_in,
    input  logic         dir_in,
    output logic         rise,
    output logic         fall,
    output logic [W-1:0] data_s,
    output logic         start_s,
    output logic         xfer_s,
    output logic         esel_s,
    output logic         dir_s
);
    typedef struct packed {
        logic         pclk;
        logic [W-1:0] data;
        logic         start;
        logic         xfer;
        logic         esel;
        logic         dir;
    } smp_t;

    typedef struct packed {
        smp_t s1;
        smp_t s2;
        logic pclk3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.s1.pclk  = pclk_in;
        sync_d.s1.data  = data_in;
        sync_d.s1.start = start_in;
        sync_d.s1.xfer  = xfer_in;
        sync_d.s1.esel  = esel_in;
        sync_d.s1.dir   = dir_in;
        sync_d.s2       = sync_q.s1;
        sync_d.pclk3    = sync_q.s2.pclk;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign rise    =  sync_q.s2.pclk & ~sync_q.pclk3;
    assign fall    = ~sync_q.s2.pclk &  sync_q.pclk3;
    assign data_s  = sync_q.s2.data;
    assign start_s = sync_q.s2.start;
    assign xfer_s  = sync_q.s2.xfer;
    assign esel_s  = sync_q.s2.esel;
    assign dir_s   = sync_q.s2.dir;
endmodule

// File: rtl/hls_seq_ctrl.sv
module hls_seq_ctrl #(
    parameter int unsigned CH_N  = hls_pkg::CH_N,
    parameter int unsigned IDX_W = hls_pkg::IDX_W,
    parameter int unsigned CNT_W = hls_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act,
    input  logic             start_s,
    input  logic             dir_s,
    output logic [CH_N-1:0]  ld_en,
    output logic             seq_done,
    output logic [IDX_W-1:0] next_ch
);
    localparam logic [IDX_W-1:0] LAST   = IDX_W'(CH_N - 1);
    localparam logic [CNT_W-1:0] FINAL  = CNT_W'(CH_N - 1);

    typedef struct packed {
        logic             arm;
        logic             busy;
        logic             done;
        logic             down;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic             go;
    logic [IDX_W-1:0] sel;

    always_comb begin
        seq_d = seq_q;
        go    = 1'b0;
        sel   = '0;
        if (act) begin
            if (seq_q.arm) begin
                go         = 1'b1;
                sel        = dir_s ? LAST : '0;
                seq_d.down = dir_s;
                seq_d.busy = 1'b1;
                seq_d.done = 1'b0;
                seq_d.cnt  = CNT_W'(1);
                seq_d.idx  = dir_s ? LAST - 1'b1 : IDX_W'(1);
            end else if (seq_q.busy) begin
                go  = 1'b1;
                sel = seq_q.idx;
                if (seq_q.cnt == FINAL) begin
                    seq_d.busy = 1'b0;
                    seq_d.done = 1'b1;
                    seq_d.idx  = '0;
                    seq_d.cnt  = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                    seq_d.idx = seq_q.down ? seq_q.idx - 1'b1 : seq_q.idx + 1'b1;
                end
            end
            seq_d.arm = start_s;
        end
    end

    for (genvar g = 0; g < CH_N; g++) begin : g_dec
        assign ld_en[g] = go && (sel == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign seq_done = seq_q.done;
    assign next_ch  = seq_q.idx;

    assert_onehot_load_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ld_en));
    assert_load_needs_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (|ld_en) |-> act);
    assert_done_after_load_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_done) |-> $past(|ld_en));
    assert_next_range_R9: assert property (@(posedge clk) disable iff (rst)
        next_ch <= LAST);
endmodule

// File: rtl/hls_stage_bank.sv
module hls_stage_bank #(
    parameter int unsigned CH_N = hls_pkg::CH_N,
    parameter int unsigned W    = hls_pkg::WORD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CH_N-1:0] ld_en,
    input  logic [W-1:0]    word,
    input  logic            copy,
    output logic [CH_N*W-1:0] out_flat
);
    typedef struct packed {
        logic [CH_N-1:0][W-1:0] ld;
        logic [CH_N-1:0][W-1:0] outr;
    } bank_t;

    bank_t bank_d, bank_q;

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        always_comb begin
            bank_d.ld[g]   = ld_en[g] ? word : bank_q.ld[g];
            bank_d.outr[g] = copy ? bank_q.ld[g] : bank_q.outr[g];
        end
        assign out_flat[g*W +: W] = bank_q.outr[g];
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    assert_copy_all_R7: assert property (@(posedge clk) disable iff (rst)
        copy |=> (bank_q.outr == $past(bank_q.ld)));
    assert_hold_out_R8: assert property (@(posedge clk) disable iff (rst)
        !copy |=> $stable(bank_q.outr));
endmodule

// File: rtl/hexa_load_sequencer.sv
module hexa_load_sequencer #(
    parameter int unsigned CH_N   = hls_pkg::CH_N,
    parameter int unsigned WORD_W = hls_pkg::WORD_W,
    parameter int unsigned IDX_W  = hls_pkg::IDX_W,
    parameter int unsigned CNT_W  = hls_pkg::CNT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pclk_in,
    input  logic                   edge_sel,
    input  logic                   dir_sel,
    input  logic                   start_in,
    input  logic                   xfer_in,
    input  logic [WORD_W-1:0]      data_in,
    output logic [CH_N*WORD_W-1:0] ch_out,
    output logic                   seq_done,
    output logic [IDX_W-1:0]       next_ch
);
    logic              rise, fall, start_s, xfer_s, esel_s, dir_s;
    logic [WORD_W-1:0] data_s;
    logic [CH_N-1:0]   ld_en;
    logic              act, copy;

    typedef struct packed {
        logic pend;
    } xfr_t;

    xfr_t xfr_d, xfr_q;

    hls_edge_sync #(.W(WORD_W)) u_sync (
        .clk(clk), .rst(rst), .pclk_in(pclk_in), .data_in(data_in),
        .start_in(start_in), .xfer_in(xfer_in), .esel_in(edge_sel),
        .dir_in(dir_sel), .rise(rise), .fall(fall), .data_s(data_s),
        .start_s(start_s), .xfer_s(xfer_s), .esel_s(esel_s), .dir_s(dir_s)
    );

    always_comb begin
        act   = esel_s ? rise : fall;
        copy  = fall & xfr_q.pend;
        xfr_d = xfr_q;
        if (rise)      xfr_d.pend = xfer_s;
        else if (fall) xfr_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) xfr_q <= '0;
        else     xfr_q <= xfr_d;
    end

    hls_seq_ctrl #(.CH_N(CH_N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .act(act), .start_s(start_s), .dir_s(dir_s),
        .ld_en(ld_en), .seq_done(seq_done), .next_ch(next_ch)
    );

    hls_stage_bank #(.CH_N(CH_N), .W(WORD_W)) u_bank (
        .clk(clk), .rst(rst), .ld_en(ld_en), .word(data_s), .copy(copy),
        .out_flat(ch_out)
    );

    assert_copy_only_after_req_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(xfr_q.pend) |-> $past(rise && xfer_s));
endmodule

// File: tb/hexa_load_sequencer_bench.sv
module hexa_load_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pclk_in = 1'b0, edge_sel = 1'b1, dir_sel = 1'b0;
    logic       start_in = 1'b0, xfer_in = 1'b0;
    logic [9:0] data_in = '0;
    logic [59:0] ch_out;
    logic       seq_done;
    logic [2:0] next_ch;

    always #2 clk = ~clk;

    hexa_load_sequencer u_hexa_load_sequencer (
        .clk(clk), .rst(rst), .pclk_in(pclk_in), .edge_sel(edge_sel),
        .dir_sel(dir_sel), .start_in(start_in), .xfer_in(xfer_in),
        .data_in(data_in), .ch_out(ch_out), .seq_done(seq_done),
        .next_ch(next_ch)
    );

    typedef struct {
        logic [59:0] outv;
        logic        done;
        logic [2:0]  nxt;
        string       tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_chk = 0, n_bad = 0;
    bit   finished = 0;

    logic [9:0] m_ld [6];
    logic [9:0] m_out[6];
    logic       m_arm, m_busy, m_done, m_down, m_pend;
    int         m_idx, m_cnt;
    logic       es_g = 1'b1, dir_g = 1'b0;

    function automatic void model_reset();
        for (int i = 0; i < 6; i++) begin m_ld[i] = '0; m_out[i] = '0; end
        m_arm = 0; m_busy = 0; m_done = 0; m_down = 0; m_pend = 0;
        m_idx = 0; m_cnt = 0;
    endfunction

    function automatic void model_step(logic lvl, logic [9:0] d, logic st, logic xf);
        logic rs, active;
        rs = lvl;
        active = es_g ? rs : !rs;
        if (!rs && m_pend) for (int i = 0; i < 6; i++) m_out[i] = m_ld[i];
        if (rs) m_pend = xf; else m_pend = 0;
        if (active) begin
            if (m_arm) begin
                m_down = dir_g;
                m_ld[dir_g ? 5 : 0] = d;
                m_busy = 1; m_done = 0; m_cnt = 1;
                m_idx = dir_g ? 4 : 1;
            end else if (m_busy) begin
                m_ld[m_idx] = d;
                if (m_cnt == 5) begin
                    m_busy = 0; m_done = 1; m_idx = 0; m_cnt = 0;
                end else begin
                    m_cnt++;
                    m_idx = m_down ? m_idx - 1 : m_idx + 1;
                end
            end
            m_arm = st;
        end
    endfunction

    function automatic exp_t snap(string tag);
        exp_t e;
        for (int i = 0; i < 6; i++) e.outv[i*10 +: 10] = m_out[i];
        e.done = m_done;
        e.nxt  = 3'(m_idx);
        e.tag  = tag;
        return e;
    endfunction

    // driver: one panel-clock transition, result due three cycles later (R10)
    task automatic half(input logic lvl, input logic [9:0] d, input logic st,
                        input logic xf, input string tag);
        @(negedge clk);
        pclk_in = lvl; data_in = d; start_in = st; xfer_in = xf;
        edge_sel = es_g; dir_sel = dir_g;
        model_step(lvl, d, st, xf);
        repeat (3) @(negedge clk);
        q.push_back(snap(tag));
        -> chk_ev;
        repeat (4) @(negedge clk);
    endtask

    // monitor
    initial forever begin
        @(chk_ev);
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk += 3;
            if (ch_out !== e.outv) begin
                n_bad++;
                $display("FAIL %s R10 ch_out actual=%h expected=%h", e.tag, ch_out, e.outv);
            end
            if (seq_done !== e.done) begin
                n_bad++;
                $display("FAIL %s seq_done actual=%b expected=%b", e.tag, seq_done, e.done);
            end
            if (next_ch !== e.nxt) begin
                n_bad++;
                $display("FAIL %s R9 next_ch actual=%0d expected=%0d", e.tag, next_ch, e.nxt);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        q.push_back(snap("R1 reset"));
        -> chk_ev;
        @(negedge clk);

        // rising-edge mode, ascending
        es_g = 1; dir_g = 0;
        half(1, 10'h3FF, 1, 0, "R3 arm");
        half(0, 10'h111, 0, 0, "R2 inactive fall");
        for (int k = 0; k < 6; k++) begin
            half(1, 10'h040 + 10'(k), 0, 0, "R4 up load");
            half(0, 10'h155, 0, 0, "R2 fall ignored");
        end
        half(1, 10'h2AA, 0, 0, "R5 extra ignored");
        half(0, 10'h000, 0, 0, "R5 idle");
        half(1, 10'h000, 0, 1, "R7 request");
        half(0, 10'h000, 0, 0, "R7 copy");
        half(1, 10'h000, 0, 0, "R8 no request");
        half(0, 10'h000, 0, 0, "R8 hold");

        // falling-edge mode, descending
        es_g = 0; dir_g = 1;
        half(1, 10'h0F0, 0, 0, "R2 inactive rise");
        half(0, 10'h0F1, 1, 0, "R3 arm fall");
        for (int k = 0; k < 6; k++) begin
            half(1, 10'h3C3, 0, 0, "R2 rise ignored");
            half(0, 10'h200 + 10'(k), 0, 0, "R4 down load");
        end
        half(1, 10'h000, 0, 1, "R7 request");
        half(0, 10'h123, 0, 0, "R7 copy");

        // restart mid-sequence, rising mode ascending
        es_g = 1; dir_g = 0;
        half(1, 10'h001, 1, 0, "R3 arm");
        half(0, 10'h000, 0, 0, "R2");
        half(1, 10'h0A1, 0, 0, "R4");
        half(0, 10'h000, 0, 0, "R2");
        half(1, 10'h0A2, 0, 0, "R4");
        half(0, 10'h000, 0, 0, "R2");
        half(1, 10'h0A3, 1, 0, "R6 start mid");
        half(0, 10'h000, 0, 0, "R2");
        half(1, 10'h0B0, 0, 0, "R6 restart ch0");
        half(0, 10'h000, 0, 0, "R2");
        half(1, 10'h0B1, 0, 0, "R6 continue");
        half(0, 10'h000, 0, 0, "R2");

        // transfer while loading, rising mode
        half(1, 10'h0B2, 0, 1, "R7 request mid-load");
        half(0, 10'h000, 0, 0, "R7 copy mid-load");
        half(1, 10'h0B3, 0, 0, "R8");
        half(0, 10'h000, 0, 0, "R8 hold");

        // transfer while loading, falling mode: copy sees pre-load contents
        es_g = 0; dir_g = 0;
        half(1, 10'h000, 0, 0, "R2");
        half(0, 10'h000, 1, 0, "R3 arm");
        half(1, 10'h000, 0, 0, "R2");
        half(0, 10'h301, 0, 0, "R4");
        half(1, 10'h000, 0, 1, "R7 request");
        half(0, 10'h302, 0, 0, "R7 same-edge load excluded");
        half(1, 10'h000, 0, 1, "R7 request");
        half(0, 10'h303, 0, 0, "R7 copy");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule